// File: doc/BRIEF.md
# Wrap-Aware Command Fetch Splitter

This block copies the pending entries of a circular command queue in host memory into a smaller local packet ring. It works out how many host entries are waiting and asks the local ring for that many slots. It then issues DMA read requests that together cover exactly the slots it was granted. No single request runs past the end of the host queue or past the end of the local ring. A request ends wherever the first of those two boundaries falls, or where the work runs out.

A fetch is started by a kick pulse, typically a doorbell write. A fetch that stopped for lack of local space is started again by itself when a local slot retires. The block remembers how many packets of the current series are still in flight. It counts each DMA completion against that total. When the last packet has landed, it clears its busy flag and pulses a request for the packet processor to look at the queue. Only one DMA request is presented at a time, and it is held steady until the DMA engine takes it.

Top module: `cmd_fetch_splitter`

## Requirements
- R1: After reset the host read index is 0, and no allocation or DMA request is raised. The in-progress, stall and process-request outputs are all low.
- R2: While a fetch series is in progress (`fetch_active` high), a kick or retire trigger is refused and raises no allocation request.
- R3: A trigger when the host read and write indices are equal raises no allocation request and changes no state.
- R4: An accepted trigger raises `alloc_req` one cycle later, with `alloc_num` equal to the pending count (write index minus read index, modulo 2·HQ_DEPTH). On the grant, the host read index advances by `grant_num`.
- R5: A zero grant sets `stall_flag` and issues no DMA request. A nonzero grant clears `stall_flag`.
- R6: The first burst of a series targets local slot (`loc_wr_pos` − `grant_num`) modulo LR_DEPTH, where `loc_wr_pos` is the local write position after the grant.
- R7: Each burst length is the smallest of four values: host entries before the host wrap, local entries before the local wrap, host entries still to move, and granted entries still to use.
- R8: Bursts follow back to back. After each accepted burst both positions advance by its length modulo their ring depths, and the burst lengths add up to the grant.
- R9: If the grant runs out while host entries remain, `stall_flag` is set after the last burst is accepted.
- R10: Each `cpl_vld` retires the oldest outstanding burst. When the retired lengths reach the grant, `fetch_active` falls and `proc_req` pulses for exactly one cycle.
- R11: A `slot_retire` pulse while `stall_flag` is set starts a new fetch. When `stall_flag` is clear, a `slot_retire` pulse has no effect.
- R12: `dma_addr` equals `host_base` plus the host slot times 64, and `dma_bytes` equals the burst length times 64.
- R13: While `dma_req_vld` is high and `dma_req_rdy` is low, the request and all its fields stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kick | input | 1 | Fetch trigger pulse (doorbell) |
| slot_retire | input | 1 | A local ring slot has retired |
| host_base | input | ADDR_W | Byte address of host queue slot 0 |
| host_wr_idx | input | log2(HQ_DEPTH)+1 | Host queue write index with wrap bit |
| host_rd_idx | output | log2(HQ_DEPTH)+1 | Host queue read index with wrap bit |
| alloc_req | output | 1 | Local slot allocation request |
| alloc_num | output | CNT_W | Number of slots asked for |
| grant_vld | input | 1 | Allocation answer valid |
| grant_num | input | CNT_W | Number of slots granted (may be 0) |
| loc_wr_pos | input | log2(LR_DEPTH) | Local write position after the grant |
| dma_req_vld | output | 1 | DMA read request valid |
| dma_req_rdy | input | 1 | DMA engine accepts the request |
| dma_addr | output | ADDR_W | Host byte address of the burst |
| dma_bytes | output | CNT_W+6 | Burst length in bytes |
| dma_lslot | output | log2(LR_DEPTH) | First local slot of the burst |
| cpl_vld | input | 1 | Oldest outstanding burst has completed |
| fetch_active | output | 1 | A fetch series is in progress |
| stall_flag | output | 1 | Fetch stopped for lack of local space |
| proc_req | output | 1 | One-cycle request to process the queue |

## Verification
The assertions rely on three things from the surroundings. The grant never exceeds the slots asked for and never exceeds the free space of the local ring. `host_base` stays constant while bursts are out. `cpl_vld` arrives only for bursts already accepted, in order. The stimulus meets these conditions by design. It always grants the smaller of the request and a configured free count of at most LR_DEPTH. It sets the base once, and it pulses completions only after counting the accepted bursts. The sequence covers a host wrap, a local wrap, a partial grant, a zero grant, and a retry on retire. A final loop varies the pending count, the free space and the handshake gaps.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_ALLOC = 2'd1,
        FS_BURST = 2'd2
    } fetch_state_e;

    localparam int unsigned DEF_PKT_BYTES = 64;

    function automatic logic [31:0] min2(input logic [31:0] a, input logic [31:0] b);
        return (a < b) ? a : b;
    endfunction

    function automatic logic [31:0] min4(input logic [31:0] a, input logic [31:0] b,
                                         input logic [31:0] c, input logic [31:0] d);
        return min2(min2(a, b), min2(c, d));
    endfunction

endpackage

// File: rtl/cfs_burst_calc.sv
module cfs_burst_calc #(
    parameter int HQ_DEPTH = 16,
    parameter int LR_DEPTH = 8,
    parameter int CNT_W    = 5,
    localparam int HPOS_W  = $clog2(HQ_DEPTH),
    localparam int LPOS_W  = $clog2(LR_DEPTH)
) (
    input  logic [HPOS_W-1:0] hpos,
    input  logic [LPOS_W-1:0] lpos,
    input  logic [CNT_W-1:0]  host_left,
    input  logic [CNT_W-1:0]  grant_left,
    output logic [CNT_W-1:0]  blen,
    output logic [HPOS_W-1:0] hpos_nxt,
    output logic [LPOS_W-1:0] lpos_nxt
);
    logic [CNT_W-1:0] hroom;
    logic [CNT_W-1:0] lroom;

    always_comb begin
        hroom    = CNT_W'(HQ_DEPTH) - CNT_W'(hpos);
        lroom    = CNT_W'(LR_DEPTH) - CNT_W'(lpos);
        blen     = CNT_W'(cfs_pkg::min4(32'(hroom), 32'(lroom),
                                        32'(host_left), 32'(grant_left)));
        hpos_nxt = HPOS_W'(CNT_W'(hpos) + blen);
        lpos_nxt = LPOS_W'(CNT_W'(lpos) + blen);
    end

endmodule

// File: rtl/cfs_len_fifo.sv
module cfs_len_fifo #(
    parameter int DEPTH  = 4,
    parameter int W      = 5,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty
);
    logic [W-1:0]     slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W:0]   fill;

    assign head  = slots[rd_ptr];
    assign empty = (fill == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
        end else begin
            if (push) begin
                slots[wr_ptr] <= push_data;
                wr_ptr        <= wr_ptr + 1'b1;
            end
            if (pop) rd_ptr <= rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

endmodule

// File: rtl/cfs_series_tracker.sv
module cfs_series_tracker #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             cpl_en,
    input  logic [CNT_W-1:0] cpl_len,
    output logic             active,
    output logic             done_pulse
);
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain     <= '0;
            active     <= 1'b0;
            done_pulse <= 1'b0;
        end else begin
            done_pulse <= 1'b0;
            if (load) begin
                remain <= load_val;
                active <= 1'b1;
            end else if (cpl_en) begin
                if (remain == cpl_len) begin
                    remain     <= '0;
                    active     <= 1'b0;
                    done_pulse <= 1'b1;
                end else begin
                    remain <= remain - cpl_len;
                end
            end
        end
    end

endmodule

// File: rtl/cmd_fetch_splitter.sv
module cmd_fetch_splitter #(
    parameter int HQ_DEPTH   = 16,
    parameter int LR_DEPTH   = 8,
    parameter int ADDR_W     = 32,
    parameter int PKT_BYTES  = cfs_pkg::DEF_PKT_BYTES,
    parameter int OUTQ_DEPTH = 4,
    localparam int HPOS_W    = $clog2(HQ_DEPTH),
    localparam int LPOS_W    = $clog2(LR_DEPTH),
    localparam int HIDX_W    = HPOS_W + 1,
    localparam int CNT_W     = ((HPOS_W > LPOS_W) ? HPOS_W : LPOS_W) + 1,
    localparam int PKT_SHIFT = $clog2(PKT_BYTES),
    localparam int BYTES_W   = CNT_W + PKT_SHIFT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               kick,
    input  logic               slot_retire,
    input  logic [ADDR_W-1:0]  host_base,
    input  logic [HIDX_W-1:0]  host_wr_idx,
    output logic [HIDX_W-1:0]  host_rd_idx,
    output logic               alloc_req,
    output logic [CNT_W-1:0]   alloc_num,
    input  logic               grant_vld,
    input  logic [CNT_W-1:0]   grant_num,
    input  logic [LPOS_W-1:0]  loc_wr_pos,
    output logic               dma_req_vld,
    input  logic               dma_req_rdy,
    output logic [ADDR_W-1:0]  dma_addr,
    output logic [BYTES_W-1:0] dma_bytes,
    output logic [LPOS_W-1:0]  dma_lslot,
    input  logic               cpl_vld,
    output logic               fetch_active,
    output logic               stall_flag,
    output logic               proc_req
);
    import cfs_pkg::*;

    fetch_state_e      state_q;
    logic [HIDX_W-1:0] hrd_q;
    logic [CNT_W-1:0]  want_q;
    logic [HPOS_W-1:0] hpos_q;
    logic [LPOS_W-1:0] lpos_q;
    logic [CNT_W-1:0]  hleft_q;
    logic [CNT_W-1:0]  gleft_q;
    logic              stall_q;

    logic [HIDX_W-1:0] pending;
    logic              trigger;
    logic              start_fetch;
    logic              burst_take;
    logic [CNT_W-1:0]  blen;
    logic [HPOS_W-1:0] hpos_nxt;
    logic [LPOS_W-1:0] lpos_nxt;
    logic [LPOS_W-1:0] first_lslot;
    logic [CNT_W-1:0]  fifo_head;
    logic              fifo_empty;
    logic              cpl_en;
    logic              load_series;

    // trigger qualification
    always_comb begin
        pending     = host_wr_idx - hrd_q;
        trigger     = kick | (slot_retire & stall_q);
        start_fetch = (state_q == FS_IDLE) && trigger && !fetch_active && (pending != '0);
        burst_take  = (state_q == FS_BURST) && dma_req_rdy;
        load_series = (state_q == FS_ALLOC) && grant_vld && (grant_num != '0);
        first_lslot = LPOS_W'(CNT_W'(loc_wr_pos) - grant_num);
        cpl_en      = cpl_vld && !fifo_empty;
    end

    cfs_burst_calc #(
        .HQ_DEPTH(HQ_DEPTH),
        .LR_DEPTH(LR_DEPTH),
        .CNT_W   (CNT_W)
    ) u_calc (
        .hpos      (hpos_q),
        .lpos      (lpos_q),
        .host_left (hleft_q),
        .grant_left(gleft_q),
        .blen      (blen),
        .hpos_nxt  (hpos_nxt),
        .lpos_nxt  (lpos_nxt)
    );

    cfs_len_fifo #(
        .DEPTH(OUTQ_DEPTH),
        .W    (CNT_W)
    ) u_outq (
        .clk      (clk),
        .rst      (rst),
        .push     (burst_take),
        .push_data(blen),
        .pop      (cpl_en),
        .head     (fifo_head),
        .empty    (fifo_empty)
    );

    cfs_series_tracker #(
        .CNT_W(CNT_W)
    ) u_track (
        .clk       (clk),
        .rst       (rst),
        .load      (load_series),
        .load_val  (grant_num),
        .cpl_en    (cpl_en),
        .cpl_len   (fifo_head),
        .active    (fetch_active),
        .done_pulse(proc_req)
    );

    // sequencing of one fetch: allocate, then split into bursts
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_IDLE;
            hrd_q   <= '0;
            want_q  <= '0;
            hpos_q  <= '0;
            lpos_q  <= '0;
            hleft_q <= '0;
            gleft_q <= '0;
            stall_q <= 1'b0;
        end else begin
            case (state_q)
                FS_IDLE: begin
                    if (start_fetch) begin
                        want_q  <= CNT_W'(pending);
                        state_q <= FS_ALLOC;
                    end
                end
                FS_ALLOC: begin
                    if (grant_vld) begin
                        if (grant_num == '0) begin
                            stall_q <= 1'b1;
                            state_q <= FS_IDLE;
                        end else begin
                            stall_q <= 1'b0;
                            hrd_q   <= HIDX_W'(CNT_W'(hrd_q) + grant_num);
                            hpos_q  <= HPOS_W'(hrd_q);
                            lpos_q  <= first_lslot;
                            hleft_q <= want_q;
                            gleft_q <= grant_num;
                            state_q <= FS_BURST;
                        end
                    end
                end
                FS_BURST: begin
                    if (dma_req_rdy) begin
                        hpos_q  <= hpos_nxt;
                        lpos_q  <= lpos_nxt;
                        hleft_q <= hleft_q - blen;
                        gleft_q <= gleft_q - blen;
                        if (gleft_q == blen) begin
                            stall_q <= (hleft_q != blen);
                            state_q <= FS_IDLE;
                        end
                    end
                end
                default: state_q <= FS_IDLE;
            endcase
        end
    end

    always_comb begin
        host_rd_idx = hrd_q;
        alloc_req   = (state_q == FS_ALLOC);
        alloc_num   = want_q;
        dma_req_vld = (state_q == FS_BURST);
        dma_addr    = host_base + (ADDR_W'(hpos_q) << PKT_SHIFT);
        dma_bytes   = BYTES_W'(blen) << PKT_SHIFT;
        dma_lslot   = lpos_q;
        stall_flag  = stall_q;
    end

endmodule

// File: rtl/cfs_checker.sv
module cfs_checker #(
    parameter int HQ_DEPTH   = 16,
    parameter int LR_DEPTH   = 8,
    parameter int ADDR_W     = 32,
    parameter int PKT_BYTES  = 64,
    localparam int HPOS_W    = $clog2(HQ_DEPTH),
    localparam int LPOS_W    = $clog2(LR_DEPTH),
    localparam int HIDX_W    = HPOS_W + 1,
    localparam int CNT_W     = ((HPOS_W > LPOS_W) ? HPOS_W : LPOS_W) + 1,
    localparam int PKT_SHIFT = $clog2(PKT_BYTES),
    localparam int BYTES_W   = CNT_W + PKT_SHIFT
) (
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  host_base,
    input logic [HIDX_W-1:0]  host_rd_idx,
    input logic               alloc_req,
    input logic [CNT_W-1:0]   alloc_num,
    input logic               grant_vld,
    input logic [CNT_W-1:0]   grant_num,
    input logic               dma_req_vld,
    input logic               dma_req_rdy,
    input logic [ADDR_W-1:0]  dma_addr,
    input logic [BYTES_W-1:0] dma_bytes,
    input logic [LPOS_W-1:0]  dma_lslot,
    input logic               fetch_active,
    input logic               stall_flag,
    input logic               proc_req
);
    logic [63:0] burst_pkts;
    logic [63:0] host_slot;

    assign burst_pkts = 64'(dma_bytes) >> PKT_SHIFT;
    assign host_slot  = 64'(dma_addr - host_base) >> PKT_SHIFT;

    // R13: request held until taken
    assert_req_stable_R13: assert property (@(posedge clk) disable iff (rst)
        (dma_req_vld && !dma_req_rdy) |=> (dma_req_vld && $stable(dma_addr)
                                           && $stable(dma_bytes) && $stable(dma_lslot)));

    // R7: no burst crosses the host ring end
    assert_host_nowrap_R7: assert property (@(posedge clk) disable iff (rst)
        dma_req_vld |-> (burst_pkts != 0) && (host_slot + burst_pkts <= 64'(HQ_DEPTH)));

    // R7: no burst crosses the local ring end
    assert_local_nowrap_R7: assert property (@(posedge clk) disable iff (rst)
        dma_req_vld |-> (64'(dma_lslot) + burst_pkts <= 64'(LR_DEPTH)));

    // R5: zero grant stalls without DMA
    assert_zero_grant_R5: assert property (@(posedge clk) disable iff (rst)
        (alloc_req && grant_vld && grant_num == '0) |=> (stall_flag && !dma_req_vld));

    // R4: read index advances by the grant
    assert_rd_advance_R4: assert property (@(posedge clk) disable iff (rst)
        (alloc_req && grant_vld) |=>
            (host_rd_idx == HIDX_W'(CNT_W'($past(host_rd_idx)) + $past(grant_num))));

    // R3: an allocation never asks for zero slots
    assert_nonempty_alloc_R3: assert property (@(posedge clk) disable iff (rst)
        alloc_req |-> (alloc_num != '0));

    // R2: no new allocation during a series
    assert_refuse_busy_R2: assert property (@(posedge clk) disable iff (rst)
        alloc_req |-> !fetch_active);

    // R10: process request is a single-cycle pulse after the series ends
    assert_proc_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        proc_req |-> (!fetch_active ##1 !proc_req));

endmodule

bind cmd_fetch_splitter cfs_checker #(
    .HQ_DEPTH (HQ_DEPTH),
    .LR_DEPTH (LR_DEPTH),
    .ADDR_W   (ADDR_W),
    .PKT_BYTES(PKT_BYTES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_base   (host_base),
    .host_rd_idx (host_rd_idx),
    .alloc_req   (alloc_req),
    .alloc_num   (alloc_num),
    .grant_vld   (grant_vld),
    .grant_num   (grant_num),
    .dma_req_vld (dma_req_vld),
    .dma_req_rdy (dma_req_rdy),
    .dma_addr    (dma_addr),
    .dma_bytes   (dma_bytes),
    .dma_lslot   (dma_lslot),
    .fetch_active(fetch_active),
    .stall_flag  (stall_flag),
    .proc_req    (proc_req)
);

// File: tb/sim_cmd_fetch_splitter.sv
`timescale 1ns/1ps
module sim_cmd_fetch_splitter;
    localparam int HQ   = 16;
    localparam int LR   = 8;
    localparam int AW   = 32;
    localparam int HIW  = 5;
    localparam int LPW  = 3;
    localparam int CW   = 5;
    localparam int BW   = CW + 6;
    localparam logic [AW-1:0] BASE = 32'h1000_0000;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           kick = 1'b0;
    logic           slot_retire = 1'b0;
    logic [AW-1:0]  host_base = BASE;
    logic [HIW-1:0] host_wr_idx = '0;
    logic [HIW-1:0] host_rd_idx;
    logic           alloc_req;
    logic [CW-1:0]  alloc_num;
    logic           grant_vld = 1'b0;
    logic [CW-1:0]  grant_num = '0;
    logic [LPW-1:0] loc_wr_pos = '0;
    logic           dma_req_vld;
    logic           dma_req_rdy = 1'b0;
    logic [AW-1:0]  dma_addr;
    logic [BW-1:0]  dma_bytes;
    logic [LPW-1:0] dma_lslot;
    logic           cpl_vld = 1'b0;
    logic           fetch_active;
    logic           stall_flag;
    logic           proc_req;

    cmd_fetch_splitter u0 (
        .clk(clk), .rst(rst), .kick(kick), .slot_retire(slot_retire),
        .host_base(host_base), .host_wr_idx(host_wr_idx), .host_rd_idx(host_rd_idx),
        .alloc_req(alloc_req), .alloc_num(alloc_num), .grant_vld(grant_vld),
        .grant_num(grant_num), .loc_wr_pos(loc_wr_pos), .dma_req_vld(dma_req_vld),
        .dma_req_rdy(dma_req_rdy), .dma_addr(dma_addr), .dma_bytes(dma_bytes),
        .dma_lslot(dma_lslot), .cpl_vld(cpl_vld), .fetch_active(fetch_active),
        .stall_flag(stall_flag), .proc_req(proc_req)
    );

    always #4 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    int proc_cnt = 0;
    int env_lwr = 0;

    task automatic chk_eq(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_phase, m_want, m_hrd, m_stall, m_active, m_rem, m_proc, m_end_stall;
    int q_h[$];
    int q_l[$];
    int q_n[$];
    int outq[$];

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    always @(posedge clk) begin
        int a_old, pend, g, h, l, hl, gl, n, ln, proc_nx;
        if (rst) begin
            m_phase = 0; m_want = 0; m_hrd = 0; m_stall = 0; m_active = 0;
            m_rem = 0; m_proc = 0; m_end_stall = 0;
            q_h.delete(); q_l.delete(); q_n.delete(); outq.delete();
        end else begin
            a_old   = m_active;
            proc_nx = 0;
            if (cpl_vld && outq.size() > 0) begin
                ln = outq.pop_front();
                m_rem = m_rem - ln;
                if (m_rem == 0) begin
                    m_active = 0;
                    proc_nx  = 1;
                end
            end
            if (m_phase == 0) begin
                pend = (int'(host_wr_idx) - m_hrd + 2*HQ) % (2*HQ);
                if ((kick || (slot_retire && m_stall != 0)) && a_old == 0 && pend != 0) begin
                    m_phase = 1;
                    m_want  = pend;
                end
            end else if (m_phase == 1) begin
                if (grant_vld) begin
                    g = int'(grant_num);
                    if (g == 0) begin
                        m_stall = 1;
                        m_phase = 0;
                    end else begin
                        h  = m_hrd % HQ;
                        l  = ((int'(loc_wr_pos) - g) % LR + LR) % LR;
                        hl = m_want;
                        gl = g;
                        while (gl > 0) begin
                            n = imin(imin(HQ - h, LR - l), imin(hl, gl));
                            q_h.push_back(h); q_l.push_back(l); q_n.push_back(n);
                            h = (h + n) % HQ;
                            l = (l + n) % LR;
                            hl -= n;
                            gl -= n;
                        end
                        m_end_stall = (hl != 0) ? 1 : 0;
                        m_hrd    = (m_hrd + g) % (2*HQ);
                        m_rem    = g;
                        m_active = 1;
                        m_stall  = 0;
                        m_phase  = 2;
                    end
                end
            end else begin
                if (dma_req_rdy) begin
                    outq.push_back(q_n[0]);
                    void'(q_h.pop_front()); void'(q_l.pop_front()); void'(q_n.pop_front());
                    if (q_n.size() == 0) begin
                        m_phase = 0;
                        m_stall = m_end_stall;
                    end
                end
            end
            m_proc = proc_nx;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk_eq("R3 alloc_req", longint'(alloc_req), longint'(m_phase == 1));
            if (m_phase == 1) chk_eq("R4 alloc_num", longint'(alloc_num), longint'(m_want));
            chk_eq("R8 dma_req_vld", longint'(dma_req_vld), longint'(m_phase == 2));
            if (m_phase == 2 && dma_req_vld && q_n.size() > 0) begin
                chk_eq("R12 dma_addr", longint'(dma_addr), longint'(BASE) + 64*q_h[0]);
                chk_eq("R7 dma_bytes", longint'(dma_bytes), longint'(64*q_n[0]));
                chk_eq("R6 dma_lslot", longint'(dma_lslot), longint'(q_l[0]));
            end
            chk_eq("R4 host_rd_idx", longint'(host_rd_idx), longint'(m_hrd));
            chk_eq("R5 stall_flag", longint'(stall_flag), longint'(m_stall));
            chk_eq("R2 fetch_active", longint'(fetch_active), longint'(m_active));
            chk_eq("R10 proc_req", longint'(proc_req), longint'(m_proc));
            if (proc_req) proc_cnt++;
        end
    end

    // ---------------- stimulus ----------------
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse_kick();
        kick = 1'b1; step(); kick = 1'b0;
    endtask

    task automatic pulse_retire();
        slot_retire = 1'b1; step(); slot_retire = 1'b0;
    endtask

    // call right after the trigger step
    task automatic do_fetch(input int free_now, input int rdy_gap, input int cpl_gap,
                            input bit kick_mid, output int nb,
                            output int f_l, output longint f_addr, output int f_bytes);
        int g, guard;
        nb = 0; f_l = -1; f_addr = -1; f_bytes = -1;
        if (!alloc_req) begin
            nb = -1;
            return;
        end
        step();
        g = imin(int'(alloc_num), free_now);
        env_lwr    = (env_lwr + g) % LR;
        grant_vld  = 1'b1;
        grant_num  = CW'(g);
        loc_wr_pos = LPW'(env_lwr);
        step();
        grant_vld  = 1'b0;
        if (g == 0) return;
        guard = 0;
        while (dma_req_vld && guard < 40) begin
            repeat (rdy_gap) step();
            if (nb == 0) begin
                f_l = int'(dma_lslot); f_addr = longint'(dma_addr); f_bytes = int'(dma_bytes);
            end
            dma_req_rdy = 1'b1; step(); dma_req_rdy = 1'b0;
            nb++;
            guard++;
        end
        if (kick_mid) begin
            pulse_kick();
            chk_eq("R2 kick refused while active", longint'(alloc_req), 0);
        end
        repeat (nb) begin
            repeat (cpl_gap) step();
            cpl_vld = 1'b1; step(); cpl_vld = 1'b0;
        end
        step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int nb, fl, fb, pc;
        longint fa;
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1 reset state
        chk_eq("R1 rd idx", longint'(host_rd_idx), 0);
        chk_eq("R1 alloc_req", longint'(alloc_req), 0);
        chk_eq("R1 dma_req_vld", longint'(dma_req_vld), 0);
        chk_eq("R1 flags", longint'({fetch_active, stall_flag, proc_req}), 0);

        // R3 empty queue
        pulse_kick();
        chk_eq("R3 empty kick", longint'(alloc_req), 0);
        step();
        chk_eq("R3 rd idx unchanged", longint'(host_rd_idx), 0);

        // R11 retire without stall has no effect
        host_wr_idx = 5'd5;
        pulse_retire();
        chk_eq("R11 retire no stall", longint'(alloc_req), 0);

        // single burst
        pc = proc_cnt;
        pulse_kick();
        do_fetch(8, 0, 0, 1'b0, nb, fl, fa, fb);
        chk_eq("R7 single burst count", nb, 1);
        chk_eq("R6 first slot", fl, 0);
        chk_eq("R4 rd idx after grant", longint'(host_rd_idx), 5);
        chk_eq("R10 one proc pulse", proc_cnt - pc, 1);

        // local wrap + partial grant, kick while active
        host_wr_idx = 5'd19;
        pc = proc_cnt;
        pulse_kick();
        do_fetch(8, 2, 1, 1'b1, nb, fl, fa, fb);
        chk_eq("R8 local wrap split", nb, 2);
        chk_eq("R6 first slot wrap", fl, 5);
        chk_eq("R12 first addr", fa, longint'(BASE) + 5*64);
        chk_eq("R7 first bytes", fb, 3*64);
        chk_eq("R9 stall after partial", longint'(stall_flag), 1);
        chk_eq("R4 rd idx 13", longint'(host_rd_idx), 13);
        chk_eq("R10 single pulse", proc_cnt - pc, 1);

        // R11 retry on retire with host wrap
        pulse_retire();
        do_fetch(8, 1, 0, 1'b0, nb, fl, fa, fb);
        chk_eq("R11 retry bursts", nb, 2);
        chk_eq("R7 host wrap first bytes", fb, 3*64);
        chk_eq("R5 stall cleared", longint'(stall_flag), 0);
        chk_eq("R4 rd idx 19", longint'(host_rd_idx), 19);

        // R5 zero grant
        host_wr_idx = 5'd21;
        pulse_kick();
        do_fetch(0, 0, 0, 1'b0, nb, fl, fa, fb);
        chk_eq("R5 zero grant bursts", nb, 0);
        chk_eq("R5 zero grant stall", longint'(stall_flag), 1);
        chk_eq("R5 zero grant no dma", longint'(dma_req_vld), 0);
        chk_eq("R5 zero grant rd idx", longint'(host_rd_idx), 19);
        pulse_retire();
        do_fetch(8, 0, 2, 1'b0, nb, fl, fa, fb);
        chk_eq("R11 retry after zero grant", nb, 1);
        chk_eq("R5 stall clear", longint'(stall_flag), 0);

        // varied patterns, checked by the per-cycle model
        for (int it = 1; it <= 24; it++) begin
            int pend, fr;
            pend = (it * 7) % 17;
            fr   = (it * 5) % 9;
            host_wr_idx = HIW'((m_hrd + pend) % (2*HQ));
            pulse_kick();
            if (alloc_req) do_fetch(fr, it % 3, (it + 1) % 3, it[0], nb, fl, fa, fb);
            else step();
        end
        repeat (4) step();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule